// File: doc/BRIEF.md
# Presettable Synchronous Cascadable Counter

The block is a small synchronous counter with a configurable cycle length. By default its width is four bits. A parameter picks the counting range: a full binary range, which is 0 to 15 for four bits, or a decimal decade of 0 to 9. A second parameter can shorten the cycle to any length M below the natural range. When the count reaches M-1 and the block counts again, it reloads zero on that same clock edge. The modulus-M cycle therefore never passes through an extra short-lived state.

An active-low clear drives the count to zero at once, without waiting for a clock edge. An active-low preset copies a parallel data word into the count on a rising edge. The count advances only while both enable inputs are high. The carry output flags the last state of the cycle, and only the second enable gates it. Several stages can therefore be chained by wiring each carry output to the next stage's enables.

Top module: `sync_mod_counter`

## Requirements
- R1: While `clr_n` is 0 the count `q` is 0. Clear takes effect at once, without waiting for a clock edge, and it overrides the preset and both enables.
- R2: When `load_n` is 0 at a rising edge, `q` takes the value of `din`. When `load_n` is 1, `din` has no effect on `q`.
- R3: With `load_n` at 1, `q` goes up by one on a rising edge only if `cnt_en` and `carry_en` are both 1. If either enable is 0, `q` keeps its value.
- R4: In binary mode (`DECADE`=0, `MOD_M`=0), the count 15 is followed by 0 on a counting edge.
- R5: `rco` is 1 exactly when `q` equals the last count of the cycle and `carry_en` is 1. The value of `cnt_en` does not affect `rco`.
- R6: In decade mode (`DECADE`=1), the count runs 0,1,…,9 and then returns to 0. `rco` rises at 9.
- R7: In decade mode, a preset value from 10 to 15 is held as loaded. The next counting edge returns `q` to 0, so the counter cannot lock up.
- R8: With `MOD_M`=M>0, the count runs 0 to M-1 and goes straight to 0. No value of M or above appears from a count inside the cycle, and `rco` marks M-1.
- R9: When the binary counter runs freely, bit k of `q` toggles once every 2^k clocks. Bit 0 therefore runs at half the clock rate and bit 3 at one sixteenth of it.
- R10: Preset has priority over counting. With `load_n` at 0 and both enables at 1, `q` takes `din` rather than the incremented count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel preset, active low |
| cnt_en | input | 1 | Count enable that does not gate the carry |
| carry_en | input | 1 | Count enable that also gates `rco` |
| din | input | CNT_W | Parallel preset data |
| q | output | CNT_W | Registered count |
| rco | output | 1 | Last-count flag, gated by `carry_en` |

## Verification
Preset, count and hold all show on `q` one rising edge after the inputs are driven, because a single register lies between the inputs and `q`. The bench changes inputs 5 ns after an edge and samples 5 ns after the following edge. Clear and `rco` take effect with no clock in between. The bench checks them within the same clock period: `q` is sampled a few nanoseconds after `clr_n` falls, before the next edge arrives, and `rco` is sampled right after `carry_en` is changed.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Last count of the cycle, chosen by the parameters.
  function automatic int unsigned last_count(input int unsigned width,
                                             input bit decade,
                                             input int unsigned mod_m);
    if (mod_m != 0) return mod_m - 1;
    if (decade) return 9;
    return (1 << width) - 1;
  endfunction

  // True when the cycle covers every code of the register.
  function automatic bit full_range(input int unsigned width,
                                    input bit decade,
                                    input int unsigned mod_m);
    return last_count(width, decade, mod_m) == (1 << width) - 1;
  endfunction

endpackage

// File: rtl/cnt_term_decode.sv
module cnt_term_decode #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned LAST  = 15,
  parameter bit          FULL  = 1'b1
) (
  input  logic [CNT_W-1:0] cur,
  output logic             at_last,
  output logic             past_end
);
  localparam logic [CNT_W-1:0] LAST_V = LAST[CNT_W-1:0];

  assign at_last = (cur == LAST_V);

  generate
    if (FULL) begin : g_full
      // Every code lies inside the cycle.
      assign past_end = 1'b0;
    end else begin : g_short
      // Codes above the last count can only arrive through the preset.
      assign past_end = (cur > LAST_V);
    end
  endgenerate
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state #(
  parameter int unsigned CNT_W = 4,
  parameter bit          FULL  = 1'b1
) (
  input  logic [CNT_W-1:0] cur,
  input  logic [CNT_W-1:0] din,
  input  logic             load_n,
  input  logic             step,
  input  logic             wrap,
  output logic [CNT_W-1:0] nxt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] inc;

  generate
    if (FULL) begin : g_natural
      // The natural overflow of the adder closes the cycle.
      assign inc = cur + ONE;
    end else begin : g_reload
      // Zero is reloaded at the end of the cycle, or from an out-of-cycle code.
      assign inc = wrap ? '0 : cur + ONE;
    end
  endgenerate

  // Priority order: preset first, then count, then hold.
  always_comb begin
    if (!load_n)   nxt = din;
    else if (step) nxt = inc;
    else           nxt = cur;
  end
endmodule

// File: rtl/sync_mod_counter.sv
module sync_mod_counter #(
  parameter int unsigned CNT_W  = 4,
  parameter bit          DECADE = 1'b0,
  parameter int unsigned MOD_M  = 0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             carry_en,
  input  logic [CNT_W-1:0] din,
  output logic [CNT_W-1:0] q,
  output logic             rco
);
  localparam int unsigned LAST = cnt_pkg::last_count(CNT_W, DECADE, MOD_M);
  localparam bit          FULL = cnt_pkg::full_range(CNT_W, DECADE, MOD_M);

  logic             at_last;
  logic             past_end;
  logic [CNT_W-1:0] nxt;

  cnt_term_decode #(.CNT_W(CNT_W), .LAST(LAST), .FULL(FULL)) i_decode (
    .cur      (q),
    .at_last  (at_last),
    .past_end (past_end)
  );

  cnt_next_state #(.CNT_W(CNT_W), .FULL(FULL)) i_next (
    .cur    (q),
    .din    (din),
    .load_n (load_n),
    .step   (cnt_en & carry_en),
    .wrap   (at_last | past_end),
    .nxt    (nxt)
  );

  // The clear is asynchronous; every other change happens on the clock edge.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= nxt;
  end

  // The carry output is gated only by the carry-side enable, so stages can be chained.
  assign rco = at_last & carry_en;
endmodule

// File: rtl/sync_mod_counter_checks.sv
module sync_mod_counter_checks #(
  parameter int unsigned CNT_W  = 4,
  parameter bit          DECADE = 1'b0,
  parameter int unsigned MOD_M  = 0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             cnt_en,
  input logic             carry_en,
  input logic [CNT_W-1:0] din,
  input logic [CNT_W-1:0] q,
  input logic             rco
);
  localparam int unsigned      LAST_I = cnt_pkg::last_count(CNT_W, DECADE, MOD_M);
  localparam logic [CNT_W-1:0] LAST   = LAST_I[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ONE    = {{(CNT_W-1){1'b0}}, 1'b1};

  p_clear_zero_r1: assert property (@(posedge clk) !clr_n |-> q == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(din));

  p_hold_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && carry_en)) |=> $stable(q));

  p_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_en && q < LAST) |=> q == $past(q) + ONE);

  p_wrap_r8: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && cnt_en && carry_en && q >= LAST) |=> q == '0);

  p_rco_gate_r5: assert property (@(posedge clk) disable iff (!clr_n)
    rco |-> (carry_en && q == LAST));

  p_rco_seen_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (carry_en && q == LAST) |-> rco);
endmodule

bind sync_mod_counter sync_mod_counter_checks #(
  .CNT_W(CNT_W), .DECADE(DECADE), .MOD_M(MOD_M)
) i_checks (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
  .carry_en(carry_en), .din(din), .q(q), .rco(rco)
);

// File: tb/test_sync_mod_counter.sv
module test_sync_mod_counter;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic       cnt_en = 1'b0;
  logic       carry_en = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q_b, q_d, q_m;
  logic       rco_b, rco_d, rco_m;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  sync_mod_counter i_sync_mod_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .din(din), .q(q_b), .rco(rco_b));

  sync_mod_counter #(.DECADE(1'b1)) i_sync_mod_counter_dec (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .din(din), .q(q_d), .rco(rco_d));

  sync_mod_counter #(.MOD_M(6)) i_sync_mod_counter_m6 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .carry_en(carry_en), .din(din), .q(q_m), .rco(rco_m));

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Wait for the next rising edge, then move 5 ns past it.
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic do_clear();
    clr_n = 1'b0; load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0;
    tick();
    clr_n = 1'b1;
  endtask

  task automatic t_reset();
    tick();
    check("R1 reset q", q_b, 0);
    check("R1 reset rco", rco_b, 0);
    clr_n = 1'b1;
  endtask

  task automatic t_clear_async();
    load_n = 1'b0; din = 4'd5; tick(); load_n = 1'b1;
    check("R2 preset 5", q_b, 5);
    #3 clr_n = 1'b0;
    #1 check("R1 clear before edge", q_b, 0);
    load_n = 1'b0; din = 4'd7; cnt_en = 1'b1; carry_en = 1'b1;
    tick();
    check("R1 clear overrides preset", q_b, 0);
    clr_n = 1'b1; load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b0;
  endtask

  task automatic t_load();
    load_n = 1'b0; din = 4'd9; tick();
    check("R2 preset 9", q_b, 9);
    load_n = 1'b1; din = 4'd3; tick();
    check("R2 din ignored", q_b, 9);
  endtask

  task automatic t_count_hold();
    cnt_en = 1'b1; carry_en = 1'b0; tick();
    check("R3 hold carry_en low", q_b, 9);
    cnt_en = 1'b0; carry_en = 1'b1; tick();
    check("R3 hold cnt_en low", q_b, 9);
    cnt_en = 1'b1; tick();
    check("R3 count", q_b, 10);
    tick();
    check("R3 count again", q_b, 11);
  endtask

  task automatic t_binary_wrap();
    load_n = 1'b0; din = 4'd14; tick(); load_n = 1'b1;
    tick();
    check("R4 reach 15", q_b, 15);
    check("R5 rco at 15", rco_b, 1);
    cnt_en = 1'b0; #1;
    check("R5 rco with cnt_en low", rco_b, 1);
    carry_en = 1'b0; #1;
    check("R5 rco gated by carry_en", rco_b, 0);
    cnt_en = 1'b1; carry_en = 1'b1; tick();
    check("R4 wrap to 0", q_b, 0);
    check("R5 rco low at 0", rco_b, 0);
  endtask

  task automatic t_priority();
    load_n = 1'b0; din = 4'd4; tick(); load_n = 1'b1;
    check("R10 preset beats count", q_b, 4);
    cnt_en = 1'b0; carry_en = 1'b0;
  endtask

  task automatic t_decade();
    do_clear();
    cnt_en = 1'b1; carry_en = 1'b1;
    for (int i = 1; i <= 9; i++) begin
      tick();
      check("R6 decade step", q_d, i);
    end
    check("R6 rco at 9", rco_d, 1);
    tick();
    check("R6 decade wrap", q_d, 0);
    check("R6 rco after wrap", rco_d, 0);
  endtask

  task automatic t_decade_illegal();
    load_n = 1'b0; din = 4'd12; tick(); load_n = 1'b1;
    check("R7 loaded 12 held", q_d, 12);
    tick();
    check("R7 recover to 0", q_d, 0);
    check("R4 binary continues", q_b, 13);
    check("R8 mod6 recover", q_m, 0);
  endtask

  task automatic t_modm();
    do_clear();
    cnt_en = 1'b1; carry_en = 1'b1;
    for (int i = 1; i <= 5; i++) begin
      tick();
      check("R8 mod6 step", q_m, i);
    end
    check("R8 rco at 5", rco_m, 1);
    tick();
    check("R8 mod6 wrap no 6", q_m, 0);
  endtask

  task automatic t_divider();
    int tog[4] = '{0, 0, 0, 0};
    logic [3:0] prev;
    do_clear();
    cnt_en = 1'b1; carry_en = 1'b1;
    prev = q_b;
    for (int i = 0; i < 16; i++) begin
      tick();
      for (int k = 0; k < 4; k++) if (q_b[k] != prev[k]) tog[k]++;
      prev = q_b;
    end
    check("R9 bit0 toggles", tog[0], 16);
    check("R9 bit1 toggles", tog[1], 8);
    check("R9 bit2 toggles", tog[2], 4);
    check("R9 bit3 toggles", tog[3], 2);
    cnt_en = 1'b0; carry_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_clear_async();
    t_load();
    t_count_hold();
    t_binary_wrap();
    t_priority();
    t_decade();
    t_decade_illegal();
    t_modm();
    t_divider();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule